// File: doc/BRIEF.md
# FEAC Channel Transmit and Receive Controller

This block serves the far-end alarm and control channel of one DS3 port running C-bit parity framing. Upstream logic hands it a one-cycle strobe for every FEAC bit slot in the frame stream. It also supplies the received channel bit and takes back the bit to transmit in that slot. Frame alignment and the extraction or insertion of the channel bit in the DS3 frame stay outside this block.

The transmitter turns 6-bit codes into 16-bit codewords and sends them on the channel. A host picks one of three sequences. The first sends a single codeword. The second repeats one codeword until the host leaves that mode. The third sends a first code several times and then a second code the same number of times, back to back, which is how loopback commands are carried. The receiver finds codeword boundaries in the bit stream. A code counts as confirmed once it dominates the recent codewords. Confirmed codes go into a small queue, which a host reads through a show-ahead output. The block also reports queue-not-empty, a sticky overflow flag and a level interrupt.

Top module: `feac_ctrl`

## Requirements
- R1: While no codeword is being sent, `tx_bit` is 1. While `cbit_mode` is low, `tx_bit` is 1 at all times and a `tx_start` pulse is ignored (`tx_busy` stays 0).
- R2: A codeword for code c[5:0] is the 16 bits 0, c5, c4, c3, c2, c1, c0, 0, 1,1,1,1,1,1,1,1, sent in that order. Each `slot_stb` cycle consumes the bit currently on `tx_bit`. The first bit is present from the cycle after the accepted `tx_start`.
- R3: `tx_mode` = 0 (or 3) sends `tx_code_a` once, then `tx_busy` drops and the output idles at ones.
- R4: `tx_mode` = 1 keeps sending `tx_code_a` codewords with no gap. At each codeword end, the live `tx_mode` is sampled, and transmission stops if it is no longer 1.
- R5: `tx_mode` = 2 sends `tx_code_a` REPS times (10), then `tx_code_b` REPS times, back to back, then stops.
- R6: A received codeword is any 16-slot window of the form in R2. Its code is confirmed when it equals the code of at least HITS (8) of the last WIN (10) codewords, counting the current one.
- R7: A confirmed code is queued only if it differs from the last queued code. Sixteen consecutive received ones form an idle gap, which clears the codeword history and the last-queued memory, so the same code can be queued again.
- R8: The receive queue holds DEPTH (4) codes in arrival order. `rx_code` shows the oldest, and `rx_nempty` reports a non-empty queue. A one-cycle `rx_pop` removes the oldest entry.
- R9: A confirmed code that arrives while the queue is full is dropped, and `rx_ovf` is set. The flag stays set until `ovf_clr` is pulsed.
- R10: `irq` is high whenever `rx_nempty` or `rx_ovf` is high.
- R11: While `cbit_mode` is low, received bits are ignored and nothing is queued.
- R12: A `tx_start` pulse while `tx_busy` is high is ignored. The codes and mode in progress are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cbit_mode | input | 1 | Port framed in C-bit parity; enables the channel |
| slot_stb | input | 1 | One-cycle strobe per FEAC bit slot |
| tx_start | input | 1 | Begin a transmit sequence |
| tx_mode | input | 2 | Transmit sequence: 0 once, 1 repeat, 2 pair |
| tx_code_a | input | 6 | First (or only) code to send |
| tx_code_b | input | 6 | Second code for pair mode |
| tx_bit | output | 1 | Channel bit for the current slot |
| tx_busy | output | 1 | Transmit sequence in progress |
| rx_bit | input | 1 | Received channel bit, sampled with slot_stb |
| rx_pop | input | 1 | Remove the oldest queued code |
| rx_code | output | 6 | Oldest queued code |
| rx_nempty | output | 1 | Queue holds at least one code |
| rx_ovf | output | 1 | Sticky overflow flag |
| ovf_clr | input | 1 | Clear the overflow flag |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its defaults: a 4-entry queue, a 10-codeword window with 8 hits, and 10 repetitions per code in pair mode. With these values, five distinct codes are enough to overflow the queue. A window with two corrupted codewords lands exactly on the confirmation threshold on its tenth word. Pair mode fed back into the receiver produces two queued codes in about 320 slots. The bench drives exact bit patterns into the receiver so it can check the threshold, duplicate suppression and idle-gap cases codeword by codeword.

// File: rtl/feac_pkg.sv
package feac_pkg;
  localparam int CODE_W = 6;
  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    TXM_ONCE = 2'd0,
    TXM_LOOP = 2'd1,
    TXM_PAIR = 2'd2
  } txm_e;

  // Codeword as sent MSB first: 0, code, 0, eight ones
  function automatic logic [WORD_W-1:0] feac_word(input logic [CODE_W-1:0] code);
    return {1'b0, code, 1'b0, 8'hFF};
  endfunction

  // True when a 16-bit window (oldest bit in MSB) holds a codeword
  function automatic logic feac_is_word(input logic [WORD_W-1:0] win);
    return (win[15] == 1'b0) && (win[8] == 1'b0) && (win[7:0] == 8'hFF);
  endfunction

  function automatic logic [CODE_W-1:0] feac_field(input logic [WORD_W-1:0] win);
    return win[14:9];
  endfunction
endpackage

// File: rtl/feac_tx.sv
module feac_tx
  import feac_pkg::*;
#(
  parameter int REPS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              enable,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic [CODE_W-1:0] code_a,
  input  logic [CODE_W-1:0] code_b,
  output logic              raw_bit,
  output logic              busy
);
  localparam int BW = $clog2(WORD_W);
  localparam int RW = (REPS > 1) ? $clog2(REPS) : 1;

  logic              active;
  logic [1:0]        mode_q;
  logic [CODE_W-1:0] a_q, b_q;
  logic              phase_b;
  logic [RW-1:0]     rep;
  logic [BW-1:0]     bcnt;
  logic [WORD_W-1:0] word;
  logic [BW-1:0]     idx;
  logic              start_ok;
  logic              word_end;

  assign word     = feac_word(phase_b ? b_q : a_q);
  assign idx      = BW'(WORD_W - 1) - bcnt;
  assign raw_bit  = active ? word[idx] : 1'b1;
  assign busy     = active;
  assign start_ok = start && enable && !active;
  assign word_end = adv && active && (bcnt == BW'(WORD_W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      mode_q  <= 2'd0;
      a_q     <= '0;
      b_q     <= '0;
      phase_b <= 1'b0;
      rep     <= '0;
      bcnt    <= '0;
    end else if (start_ok) begin
      active  <= 1'b1;
      mode_q  <= mode;
      a_q     <= code_a;
      b_q     <= code_b;
      phase_b <= 1'b0;
      rep     <= '0;
      bcnt    <= '0;
    end else if (adv && active) begin
      bcnt <= bcnt + BW'(1);
      if (word_end) begin
        case (mode_q)
          TXM_LOOP: if (mode != TXM_LOOP) active <= 1'b0;
          TXM_PAIR: begin
            if (rep == RW'(REPS - 1)) begin
              rep <= '0;
              if (phase_b) active <= 1'b0;
              else phase_b <= 1'b1;
            end else begin
              rep <= rep + RW'(1);
            end
          end
          default: active <= 1'b0;
        endcase
      end
    end
  end

  // R3
  once_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_end && (mode_q == TXM_ONCE)) |=> !busy);
  // R12
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && start) |=> ($stable(a_q) && $stable(b_q) && $stable(mode_q)));
  // R1
  idle_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy) |-> raw_bit);
endmodule

// File: rtl/feac_rx.sv
module feac_rx
  import feac_pkg::*;
#(
  parameter int WIN  = 10,
  parameter int HITS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              rx_bit,
  output logic              push,
  output logic [CODE_W-1:0] push_code
);
  localparam int HW = WIN - 1;
  localparam int CW = $clog2(WIN + 1);

  logic [WORD_W-1:0] sr;
  logic              adv_q;
  logic              cw_hit;
  logic              gap;
  logic [CODE_W-1:0] new_code;
  logic [CODE_W-1:0] hist_code [HW];
  logic [HW-1:0]     hist_vld;
  logic [CW-1:0]     hits;
  logic              confirmed;
  logic [CODE_W-1:0] last_code;
  logic              have_last;

  assign cw_hit   = adv_q && feac_is_word(sr);
  assign gap      = adv_q && (sr == '1);
  assign new_code = feac_field(sr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr    <= '1;
      adv_q <= 1'b0;
    end else begin
      adv_q <= adv;
      if (adv) sr <= {sr[WORD_W-2:0], rx_bit};
    end
  end

  for (genvar g = 0; g < HW; g++) begin : g_hist
    always_ff @(posedge clk) begin
      if (!rst_n || gap) begin
        hist_vld[g]  <= 1'b0;
        hist_code[g] <= '0;
      end else if (cw_hit) begin
        if (g == 0) begin
          hist_vld[g]  <= 1'b1;
          hist_code[g] <= new_code;
        end else begin
          hist_vld[g]  <= hist_vld[g-1];
          hist_code[g] <= hist_code[g-1];
        end
      end
    end
  end

  always_comb begin
    hits = CW'(1);
    for (int i = 0; i < HW; i++)
      if (hist_vld[i] && (hist_code[i] == new_code)) hits = hits + CW'(1);
  end

  assign confirmed = cw_hit && (hits >= CW'(HITS));
  assign push      = confirmed && (!have_last || (new_code != last_code));
  assign push_code = new_code;

  always_ff @(posedge clk) begin
    if (!rst_n || gap) begin
      have_last <= 1'b0;
      last_code <= '0;
    end else if (push) begin
      have_last <= 1'b1;
      last_code <= new_code;
    end
  end

  // R6
  push_on_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cw_hit && !gap));
  // R7
  last_code_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (have_last && (last_code == $past(new_code))));
  // R7
  gap_forgets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gap |=> !have_last);
endmodule

// File: rtl/feac_fifo.sv
module feac_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         rd,
  input  logic         ovf_clr,
  output logic [W-1:0] head,
  output logic         nempty,
  output logic         ovf
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [NW-1:0] cnt;
  logic          full, do_wr, do_rd;

  assign full   = (cnt == NW'(DEPTH));
  assign nempty = (cnt != '0);
  assign do_wr  = wr && !full;
  assign do_rd  = rd && nempty;
  assign head   = mem[rp];

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      ovf <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (do_wr) begin
        mem[wp] <= wdata;
        wp      <= ptr_inc(wp);
      end
      if (do_rd) rp <= ptr_inc(rp);
      cnt <= cnt + NW'(do_wr) - NW'(do_rd);
      if (wr && full) ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;
    end
  end

  // R9
  fifo_drop_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && full) |=> ovf);
  // R8
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= NW'(DEPTH));
  // R8
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !nempty && !wr) |=> $stable(cnt));
endmodule

// File: rtl/feac_ctrl.sv
module feac_ctrl
  import feac_pkg::*;
#(
  parameter int REPS  = 10,
  parameter int WIN   = 10,
  parameter int HITS  = 8,
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cbit_mode,
  input  logic              slot_stb,
  input  logic              tx_start,
  input  logic [1:0]        tx_mode,
  input  logic [CODE_W-1:0] tx_code_a,
  input  logic [CODE_W-1:0] tx_code_b,
  output logic              tx_bit,
  output logic              tx_busy,
  input  logic              rx_bit,
  input  logic              rx_pop,
  output logic [CODE_W-1:0] rx_code,
  output logic              rx_nempty,
  output logic              rx_ovf,
  input  logic              ovf_clr,
  output logic              irq
);
  logic              slot_adv;
  logic              tx_raw;
  logic              rx_push;
  logic [CODE_W-1:0] rx_push_code;

  assign slot_adv = slot_stb && cbit_mode;

  feac_tx #(.REPS(REPS)) u_tx (
    .clk(clk), .rst_n(rst_n), .adv(slot_adv), .enable(cbit_mode),
    .start(tx_start), .mode(tx_mode), .code_a(tx_code_a), .code_b(tx_code_b),
    .raw_bit(tx_raw), .busy(tx_busy)
  );

  feac_rx #(.WIN(WIN), .HITS(HITS)) u_rx (
    .clk(clk), .rst_n(rst_n), .adv(slot_adv), .rx_bit(rx_bit),
    .push(rx_push), .push_code(rx_push_code)
  );

  feac_fifo #(.DEPTH(DEPTH), .W(CODE_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr(rx_push), .wdata(rx_push_code),
    .rd(rx_pop), .ovf_clr(ovf_clr), .head(rx_code), .nempty(rx_nempty), .ovf(rx_ovf)
  );

  assign tx_bit = cbit_mode ? tx_raw : 1'b1;
  assign irq    = rx_nempty || rx_ovf;

  // R11
  no_push_unframed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cbit_mode && $past(!cbit_mode)) |-> !rx_push);
  // R10
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ovf) |-> irq);
endmodule

// File: tb/tb_feac_ctrl.sv
module tb_feac_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cbit_mode = 1'b1;
  logic       slot_stb = 1'b0;
  logic       tx_start = 1'b0;
  logic [1:0] tx_mode = 2'd0;
  logic [5:0] tx_code_a = '0, tx_code_b = '0;
  logic       tx_bit, tx_busy;
  logic       rx_drv = 1'b1;
  logic       loop_en = 1'b0;
  logic       rx_bit;
  logic       rx_pop = 1'b0;
  logic [5:0] rx_code;
  logic       rx_nempty, rx_ovf, irq;
  logic       ovf_clr = 1'b0;

  int nvec = 0;
  int nfail = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  assign rx_bit = loop_en ? tx_bit : rx_drv;

  feac_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cbit_mode(cbit_mode), .slot_stb(slot_stb),
    .tx_start(tx_start), .tx_mode(tx_mode), .tx_code_a(tx_code_a), .tx_code_b(tx_code_b),
    .tx_bit(tx_bit), .tx_busy(tx_busy), .rx_bit(rx_bit), .rx_pop(rx_pop),
    .rx_code(rx_code), .rx_nempty(rx_nempty), .rx_ovf(rx_ovf), .ovf_clr(ovf_clr), .irq(irq)
  );

  function automatic logic [15:0] exp_word(input logic [5:0] c);
    logic [15:0] w;
    w[15] = 1'b0;
    for (int i = 0; i < 6; i++) w[14-i] = c[5-i];
    w[8] = 1'b0;
    for (int i = 0; i < 8; i++) w[i] = 1'b1;
    return w;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic slot(input logic b);
    @(negedge clk);
    rx_drv = b;
    slot_stb = 1'b1;
    @(negedge clk);
    slot_stb = 1'b0;
  endtask

  task automatic send_word(input logic [5:0] c);
    logic [15:0] w;
    w = exp_word(c);
    for (int i = 15; i >= 0; i--) slot(w[i]);
  endtask

  task automatic send_idle(input int n);
    for (int i = 0; i < n; i++) slot(1'b1);
  endtask

  task automatic cap_word(output logic [15:0] w);
    for (int i = 15; i >= 0; i--) begin
      @(negedge clk);
      w[i] = tx_bit;
      slot_stb = 1'b1;
      @(negedge clk);
      slot_stb = 1'b0;
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic pop();
    @(negedge clk);
    rx_pop = 1'b1;
    @(negedge clk);
    rx_pop = 1'b0;
  endtask

  task automatic start_tx(input logic [1:0] m, input logic [5:0] a, input logic [5:0] b);
    @(negedge clk);
    tx_mode = m;
    tx_code_a = a;
    tx_code_b = b;
    tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset tx_bit", 32'(tx_bit), 1);
    chk("R1 reset busy", 32'(tx_busy), 0);
    chk("R8 reset nempty", 32'(rx_nempty), 0);
    chk("R9 reset ovf", 32'(rx_ovf), 0);
    chk("R10 reset irq", 32'(irq), 0);
  endtask

  task automatic t_once();
    logic [15:0] w;
    start_tx(2'd0, 6'h2A, 6'h00);
    chk("R3 busy after start", 32'(tx_busy), 1);
    cap_word(w);
    chk("R2 once codeword", 32'(w), 32'(exp_word(6'h2A)));
    @(negedge clk);
    chk("R3 idle after once", 32'(tx_busy), 0);
    cap_word(w);
    chk("R1 idle ones", 32'(w), 32'hFFFF);
  endtask

  task automatic t_loop();
    logic [15:0] w;
    start_tx(2'd1, 6'h07, 6'h00);
    for (int k = 0; k < 3; k++) begin
      if (k == 1) begin
        @(negedge clk);
        tx_code_a = 6'h31;
        tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
        chk("R12 busy held", 32'(tx_busy), 1);
      end
      cap_word(w);
      chk("R4 R12 repeated word", 32'(w), 32'(exp_word(6'h07)));
    end
    tx_mode = 2'd0;
    cap_word(w);
    chk("R4 last word", 32'(w), 32'(exp_word(6'h07)));
    @(negedge clk);
    chk("R4 stops on mode change", 32'(tx_busy), 0);
  endtask

  task automatic t_pair();
    logic [15:0] w;
    int bad;
    bad = 0;
    loop_en = 1'b1;
    start_tx(2'd2, 6'h0E, 6'h23);
    for (int k = 0; k < 20; k++) begin
      cap_word(w);
      if (w !== exp_word(k < 10 ? 6'h0E : 6'h23)) bad++;
    end
    chk("R5 pair sequence mismatches", 32'(bad), 0);
    @(negedge clk);
    chk("R5 idle after pair", 32'(tx_busy), 0);
    loop_en = 1'b0;
    settle();
    chk("R6 loop first code", 32'(rx_code), 32'h0E);
    pop();
    chk("R6 loop second present", 32'(rx_nempty), 1);
    chk("R6 loop second code", 32'(rx_code), 32'h23);
    pop();
    chk("R8 drained", 32'(rx_nempty), 0);
  endtask

  task automatic t_noise();
    send_idle(20);
    send_word(6'h15); send_word(6'h15); send_word(6'h2E);
    send_word(6'h15); send_word(6'h15); send_word(6'h2E);
    send_word(6'h15); send_word(6'h15); send_word(6'h15);
    settle();
    chk("R6 seven of nine not confirmed", 32'(rx_nempty), 0);
    send_word(6'h15);
    settle();
    chk("R6 eight of ten confirmed", 32'(rx_nempty), 1);
    chk("R6 confirmed code", 32'(rx_code), 32'h15);
    chk("R10 irq on entry", 32'(irq), 1);
    pop();
    chk("R10 irq clears", 32'(irq), 0);
  endtask

  task automatic t_dup();
    send_idle(20);
    for (int k = 0; k < 12; k++) send_word(6'h19);
    settle();
    chk("R7 first push", 32'(rx_code), 32'h19);
    pop();
    chk("R7 no duplicate", 32'(rx_nempty), 0);
    send_idle(20);
    for (int k = 0; k < 8; k++) send_word(6'h19);
    settle();
    chk("R7 requeued after gap", 32'(rx_nempty), 1);
    pop();
  endtask

  task automatic t_overflow();
    send_idle(20);
    for (int c = 1; c <= 5; c++)
      for (int k = 0; k < 8; k++) send_word(6'(c * 3));
    settle();
    chk("R9 overflow set", 32'(rx_ovf), 1);
    for (int c = 1; c <= 4; c++) begin
      chk("R8 order", 32'(rx_code), 32'(c * 3));
      pop();
    end
    chk("R9 fifth dropped", 32'(rx_nempty), 0);
    chk("R10 irq from ovf", 32'(irq), 1);
    @(negedge clk);
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
    chk("R9 ovf cleared", 32'(rx_ovf), 0);
    chk("R10 irq low", 32'(irq), 0);
  endtask

  task automatic t_unframed();
    logic [15:0] w;
    send_idle(20);
    cbit_mode = 1'b0;
    start_tx(2'd1, 6'h11, 6'h00);
    chk("R1 start ignored", 32'(tx_busy), 0);
    cap_word(w);
    chk("R1 ones when unframed", 32'(w), 32'hFFFF);
    for (int k = 0; k < 10; k++) send_word(6'h11);
    settle();
    chk("R11 nothing queued", 32'(rx_nempty), 0);
    cbit_mode = 1'b1;
    send_idle(20);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        nvec++;
        nfail++;
        $display("FAIL watchdog: actual %0d expected below 150000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_once();
    t_loop();
    t_pair();
    t_noise();
    t_dup();
    t_overflow();
    t_unframed();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule